// File: doc/BRIEF.md
# Peer Doorbell Register Interface

This block is the register window that one peer of a shared-memory interconnect exposes on a simple 32-bit memory-mapped bus. It reports fixed identity information: the local peer number, the peer count and a features word. It also holds an interrupt enable and a 32-bit local state word, and it accepts doorbell writes. A doorbell write becomes a one-cycle outgoing event that names a destination peer and a vector.

Events that arrive from other peers come in on a separate input. Such an event raises a one-cycle interrupt pulse, but only while interrupt generation is enabled. A privileged one-shot input makes each delivered interrupt clear the enable, so that software must re-arm it before the next interrupt. Bus reads are registered: the data for a read strobe is presented one cycle later.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset, interrupt control reads 0, state reads 0, and neither `bellValid` nor `irqOut` is asserted.
- R2: A read of offset 00h returns LOCAL_ID, 04h returns MAX_PEERS and 08h returns FEATURES. These values never change, and writes to these offsets are ignored. Read data appears on `busRdData` in the cycle after `busRdEn` is sampled.
- R3: Offsets from 18h upward, any address with bits [1:0] not zero, and the doorbell offset 10h all read as 0. Writes to unbacked or misaligned addresses have no effect: a misaligned write neither changes a register nor produces an event.
- R4: Interrupt control sits at offset 0Ch. Bit 0 is the read/write enable, and bits 31:1 always read 0.
- R5: A write to offset 10h takes the vector from bits 15:0 and the target peer from bits 31:16. If the target is below MAX_PEERS, the write produces `bellValid` for exactly one cycle, in the cycle after the write, with `bellTarget` and `bellVector` carrying those fields. If the target is not below MAX_PEERS, the write produces no event.
- R6: An incoming event raises `irqOut` for one cycle, in the cycle after it is sampled, with `irqVector` equal to its vector. This happens only if the enable is 1 and the vector is below NUM_VECTORS. Any other incoming event is dropped and is not held pending.
- R7: When `oneShot` is 1, each delivered interrupt clears the enable. This clear takes priority over a bus write to interrupt control in the same cycle. When `oneShot` is 0, the enable stays set across deliveries.
- R8: Offset 14h is a 32-bit read/write state register. It drives `stateOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | ADDR_W | Byte address within the register window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after the read strobe |
| oneShot | input | 1 | Privileged one-shot interrupt mode |
| evtValid | input | 1 | Incoming event from a peer |
| evtVector | input | 16 | Vector of the incoming event |
| bellValid | output | 1 | Outgoing doorbell event pulse |
| bellTarget | output | 16 | Destination peer of the outgoing event |
| bellVector | output | 16 | Vector of the outgoing event |
| irqOut | output | 1 | Interrupt pulse |
| irqVector | output | 16 | Vector of the delivered interrupt |
| stateOut | output | 32 | Current local state word |

## Verification
The bench builds the block with LOCAL_ID 5, MAX_PEERS 4, NUM_VECTORS 3 and FEATURES 1. With these small values, one write can reach both sides of the target bound (peer 3 accepted, peer 4 rejected), and one event can reach both sides of the vector bound (vector 2 accepted, vector 3 dropped). The identity reads return distinct nonzero values, so a swapped decode shows up. The one-shot clear is also driven in the same cycle as a write that sets the enable, to check which of the two wins.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int unsigned OFF_ID    = 'h00;
  localparam int unsigned OFF_MAXP  = 'h04;
  localparam int unsigned OFF_FEAT  = 'h08;
  localparam int unsigned OFF_ICTL  = 'h0C;
  localparam int unsigned OFF_BELL  = 'h10;
  localparam int unsigned OFF_STATE = 'h14;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ID, SEL_MAXP, SEL_FEAT, SEL_ICTL, SEL_STATE
  } rdSel_e;

  typedef struct packed {
    logic   wrIctl;
    logic   wrBell;
    logic   wrState;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
  import pdb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);
  logic aligned;
  logic [31:0] addrWide;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign addrWide = 32'(busAddr);

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_ZERO;
    strb.rdEn  = busRdEn;
    if (aligned) begin
      if (addrWide == OFF_ID)         strb.rdSel = SEL_ID;
      else if (addrWide == OFF_MAXP)  strb.rdSel = SEL_MAXP;
      else if (addrWide == OFF_FEAT)  strb.rdSel = SEL_FEAT;
      else if (addrWide == OFF_ICTL)  strb.rdSel = SEL_ICTL;
      else if (addrWide == OFF_STATE) strb.rdSel = SEL_STATE;
      strb.wrIctl  = busWrEn && (addrWide == OFF_ICTL);
      strb.wrBell  = busWrEn && (addrWide == OFF_BELL);
      strb.wrState = busWrEn && (addrWide == OFF_STATE);
    end
  end
endmodule

// File: rtl/pdb_datapath.sv
module pdb_datapath
  import pdb_pkg::*;
#(
  parameter int unsigned LOCAL_ID    = 0,
  parameter int unsigned MAX_PEERS   = 2,
  parameter int unsigned NUM_VECTORS = 1,
  parameter logic [31:0] FEATURES    = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strb,
  input  logic [31:0] busWrData,
  input  logic        oneShot,
  input  logic        evtValid,
  input  logic [15:0] evtVector,
  output logic [31:0] busRdData,
  output logic        bellValid,
  output logic [15:0] bellTarget,
  output logic [15:0] bellVector,
  output logic        irqOut,
  output logic [15:0] irqVector,
  output logic [31:0] stateOut,
  output logic        intEn
);
  logic bellOk;
  logic evtAccept;

  assign bellOk    = strb.wrBell && (32'(busWrData[31:16]) < MAX_PEERS);
  assign evtAccept = evtValid && intEn && (32'(evtVector) < NUM_VECTORS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intEn      <= 1'b0;
      stateOut   <= '0;
      bellValid  <= 1'b0;
      bellTarget <= '0;
      bellVector <= '0;
      irqOut     <= 1'b0;
      irqVector  <= '0;
      busRdData  <= '0;
    end else begin
      if (evtAccept && oneShot) intEn <= 1'b0;
      else if (strb.wrIctl)     intEn <= busWrData[0];

      if (strb.wrState) stateOut <= busWrData;

      bellValid <= bellOk;
      if (bellOk) begin
        bellTarget <= busWrData[31:16];
        bellVector <= busWrData[15:0];
      end

      irqOut <= evtAccept;
      if (evtAccept) irqVector <= evtVector;

      if (strb.rdEn) begin
        case (strb.rdSel)
          SEL_ID:    busRdData <= 32'(LOCAL_ID);
          SEL_MAXP:  busRdData <= 32'(MAX_PEERS);
          SEL_FEAT:  busRdData <= FEATURES;
          SEL_ICTL:  busRdData <= {31'b0, intEn};
          SEL_STATE: busRdData <= stateOut;
          default:   busRdData <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned LOCAL_ID    = 0,
  parameter int unsigned MAX_PEERS   = 2,
  parameter int unsigned NUM_VECTORS = 1,
  parameter logic [31:0] FEATURES    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              oneShot,
  input  logic              evtValid,
  input  logic [15:0]       evtVector,
  output logic              bellValid,
  output logic [15:0]       bellTarget,
  output logic [15:0]       bellVector,
  output logic              irqOut,
  output logic [15:0]       irqVector,
  output logic [31:0]       stateOut
);
  ctrlStrobe_t strb;
  logic intEn;

  pdb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strb(strb)
  );

  pdb_datapath #(
    .LOCAL_ID(LOCAL_ID), .MAX_PEERS(MAX_PEERS),
    .NUM_VECTORS(NUM_VECTORS), .FEATURES(FEATURES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWrData(busWrData),
    .oneShot(oneShot), .evtValid(evtValid), .evtVector(evtVector),
    .busRdData(busRdData), .bellValid(bellValid), .bellTarget(bellTarget),
    .bellVector(bellVector), .irqOut(irqOut), .irqVector(irqVector),
    .stateOut(stateOut), .intEn(intEn)
  );
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned MAX_PEERS   = 2,
  parameter int unsigned NUM_VECTORS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              oneShot,
  input logic              evtValid,
  input logic [15:0]       evtVector,
  input logic              bellValid,
  input logic [15:0]       bellTarget,
  input logic              irqOut,
  input logic              intEn
);
  a_r5_bell_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bellValid |-> (32'(bellTarget) < MAX_PEERS));

  a_r5_bell_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    bellValid |-> $past(busWrEn && (32'(busAddr) == 32'h10)));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> $past(evtValid && intEn && (32'(evtVector) < NUM_VECTORS)));

  a_r7_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && $past(oneShot)) |-> !intEn);

  a_r1_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !intEn |=> !irqOut);
endmodule

bind peer_doorbell_regs pdb_checker #(
  .ADDR_W(ADDR_W), .MAX_PEERS(MAX_PEERS), .NUM_VECTORS(NUM_VECTORS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
  .oneShot(oneShot), .evtValid(evtValid), .evtVector(evtVector),
  .bellValid(bellValid), .bellTarget(bellTarget), .irqOut(irqOut),
  .intEn(intEn)
);

// File: tb/sim_peer_doorbell_regs.sv
module sim_peer_doorbell_regs;
  logic clk = 0;
  logic rst_n = 0;
  logic busWrEn = 0, busRdEn = 0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic oneShot = 0, evtValid = 0;
  logic [15:0] evtVector = '0;
  logic bellValid, irqOut;
  logic [15:0] bellTarget, bellVector, irqVector;
  logic [31:0] stateOut;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  peer_doorbell_regs #(
    .ADDR_W(8), .LOCAL_ID(5), .MAX_PEERS(4), .NUM_VECTORS(3), .FEATURES(32'h1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .oneShot(oneShot), .evtValid(evtValid), .evtVector(evtVector),
    .bellValid(bellValid), .bellTarget(bellTarget), .bellVector(bellVector),
    .irqOut(irqOut), .irqVector(irqVector), .stateOut(stateOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0; d = busRdData;
  endtask

  task automatic sendEvt(logic [15:0] v);
    @(negedge clk); evtValid = 1; evtVector = v;
    @(negedge clk); evtValid = 0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 bellValid", 32'(bellValid), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    busRead(8'h0C, d); check("R1 ictl", d, 0);
    busRead(8'h14, d); check("R1 state", d, 0);
  endtask

  task automatic testIdentity();
    logic [31:0] d;
    busRead(8'h00, d); check("R2 id", d, 5);
    busRead(8'h04, d); check("R2 maxPeers", d, 4);
    busRead(8'h08, d); check("R2 features", d, 1);
    busWrite(8'h00, 32'hFFFF); busWrite(8'h04, 32'h77);
    busRead(8'h00, d); check("R2 id after write", d, 5);
    busRead(8'h04, d); check("R2 maxPeers after write", d, 4);
  endtask

  task automatic testUnbacked();
    logic [31:0] d;
    busWrite(8'h18, 32'h1234); busRead(8'h18, d); check("R3 18h", d, 0);
    busRead(8'h3C, d); check("R3 3Ch", d, 0);
    busRead(8'h10, d); check("R3 doorbell read", d, 0);
    busWrite(8'h0D, 32'h1); busRead(8'h0C, d); check("R3 misaligned ictl", d, 0);
    busRead(8'h01, d); check("R3 misaligned read", d, 0);
    busWrite(8'h11, 32'h0001_0001); check("R3 misaligned bell", 32'(bellValid), 0);
  endtask

  task automatic testIctl();
    logic [31:0] d;
    busWrite(8'h0C, 32'hFFFF_FFFF); busRead(8'h0C, d); check("R4 set", d, 1);
    busWrite(8'h0C, 32'h0); busRead(8'h0C, d); check("R4 clear", d, 0);
  endtask

  task automatic testBell();
    busWrite(8'h10, {16'd2, 16'd7});
    check("R5 valid", 32'(bellValid), 1);
    check("R5 target", 32'(bellTarget), 2);
    check("R5 vector", 32'(bellVector), 7);
    @(negedge clk); check("R5 one cycle", 32'(bellValid), 0);
    busWrite(8'h10, {16'd4, 16'd1}); check("R5 target out of range", 32'(bellValid), 0);
    busWrite(8'h10, {16'd3, 16'hFFFF});
    check("R5 last peer valid", 32'(bellValid), 1);
    check("R5 last peer vector", 32'(bellVector), 32'hFFFF);
  endtask

  task automatic testIrq();
    sendEvt(16'd1); check("R6 disabled drop", 32'(irqOut), 0);
    busWrite(8'h0C, 32'h1); check("R6 no pending", 32'(irqOut), 0);
    @(negedge clk); check("R6 no pending later", 32'(irqOut), 0);
    sendEvt(16'd2);
    check("R6 irq", 32'(irqOut), 1); check("R6 irqVector", 32'(irqVector), 2);
    @(negedge clk); check("R6 one cycle", 32'(irqOut), 0);
    sendEvt(16'd3); check("R6 vector out of range", 32'(irqOut), 0);
  endtask

  task automatic testOneShot();
    logic [31:0] d;
    oneShot = 0;
    sendEvt(16'd0); check("R7 repeat irq 1", 32'(irqOut), 1);
    sendEvt(16'd1); check("R7 repeat irq 2", 32'(irqOut), 1);
    busRead(8'h0C, d); check("R7 enable kept", d, 1);
    oneShot = 1;
    sendEvt(16'd1); check("R7 oneshot irq", 32'(irqOut), 1);
    busRead(8'h0C, d); check("R7 enable cleared", d, 0);
    sendEvt(16'd1); check("R7 second dropped", 32'(irqOut), 0);
    busWrite(8'h0C, 32'h1);
    @(negedge clk); busWrEn = 1; busAddr = 8'h0C; busWrData = 32'h1;
    evtValid = 1; evtVector = 16'd0;
    @(negedge clk); busWrEn = 0; evtValid = 0;
    check("R7 same-cycle irq", 32'(irqOut), 1);
    busRead(8'h0C, d); check("R7 clear beats write", d, 0);
    oneShot = 0;
  endtask

  task automatic testState();
    logic [31:0] d;
    busWrite(8'h14, 32'hDEAD_BEEF);
    busRead(8'h14, d); check("R8 readback", d, 32'hDEAD_BEEF);
    check("R8 stateOut", stateOut, 32'hDEAD_BEEF);
    busWrite(8'h14, 32'h0000_0042);
    busRead(8'h14, d); check("R8 rewrite", d, 32'h42);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testIdentity();
    testUnbacked();
    testIctl();
    testBell();
    testIrq();
    testOneShot();
    testState();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule